// File: doc/BRIEF.md
# Multi-Pattern Test Data Generator

This block feeds a serial link transmitter with one 64-bit test word on every clock. A host-side control block drives a three-bit selector. Four codes choose a pseudo-random binary sequence (PRBS) and four choose a periodic waveform. In the PRBS modes, each clock advances the chosen linear feedback shift register by 64 steps, so successive words form one continuous bit stream. On request, the generator corrupts a single bit of one word. This lets a downstream checker be tested without losing its lock on the sequence.

In the waveform modes, a phase accumulator produces signed 16-bit samples, four per word. The shapes are sine, sawtooth, triangle and square. A change of selection restarts the chosen source from a fixed seed, with the valid flag low for one cycle. Deasserting the enable input pauses the generator in place. Everything runs in one clock domain with a synchronous active-low reset.

Top module: `test_pattern_gen`

## Requirements
- R1: Codes 0, 1, 2 and 3 of `pat_sel` select the PRBS lengths N/T = 7/6, 15/14, 23/18 and 31/28 (polynomial x^N + x^T + 1). The generated bit stream obeys b[k] = b[k-N] XOR b[k-T], and the N bits before the first bit after seeding are all ones. Within a word, `tx_data[i]` carries the i-th bit generated in that cycle, with bit 0 generated first. The next word continues the same stream.
- R2: Reset, or a selection change, sets the PRBS register to all ones. The first valid word after either event begins the stream at its start.
- R3: When `err_inject` is high at a clock edge that emits a PRBS word, that word has bit 0 inverted and no other bit changed. The following words are unaffected.
- R4: `err_inject` has no effect in waveform modes or while `gen_en` is low.
- R5: An enabled clock edge where `pat_sel` differs from the active selection emits no word. On that edge `tx_valid` goes low, the new selection becomes active, and the source restarts.
- R6: While `gen_en` is low, `tx_valid` is 0, `tx_data` holds its value and the sequence pauses. When enabled again, it resumes where it stopped.
- R7: After reset, `tx_valid` and `tx_data` are 0 and the active selection is code 0.
- R8: Waveform sample n after a restart uses phase (n * PHASE_STEP) mod 2^16. Sample k of a word occupies `tx_data[16k+15:16k]`, and each word carries four consecutive samples.
- R9: Code 5 (sawtooth) emits phase XOR 0x8000.
- R10: Code 6 (triangle) emits t XOR 0x8000. Here t is {phase[14:0],0} when phase[15] is 0, and the bitwise inverse of that value otherwise.
- R11: Code 7 (square) emits 0x7FFF when phase[15] is 0 and 0x8000 otherwise.
- R12: Code 4 (sine) meets four conditions. It rises strictly across the first quarter period. Its second quarter mirrors the first. Its second half is the negation of the first. Its peak exceeds 32700.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_sel | input | 3 | Pattern code: 0-3 PRBS7/15/23/31, 4 sine, 5 sawtooth, 6 triangle, 7 square |
| gen_en | input | 1 | Enables word generation |
| err_inject | input | 1 | Inverts bit 0 of the PRBS word emitted on this edge |
| tx_data | output | 64 | Test word |
| tx_valid | output | 1 | tx_data holds a fresh word |

## Verification
The hardest case to reach is a single corrupted word in a long PRBS run: the bench has to show that only bit 0 of one word flips and that the next word resumes the undisturbed stream. The bench keeps its own recurrence model running across the injected word, a paused stretch and re-enable. It therefore catches both a corrupted shift register and a lost or repeated step. For the sine, no exact table is assumed. Instead, the bench captures one full period and checks the symmetry and monotonic properties that any correct quarter-wave table must meet.

// File: rtl/tpg_pkg.sv
// Shared definitions for the test pattern generator: selector codes and
// the PRBS polynomial set. Assumes at most four PRBS lanes.
package tpg_pkg;
    typedef enum logic [2:0] {
        SEL_PRBS7  = 3'd0,
        SEL_PRBS15 = 3'd1,
        SEL_PRBS23 = 3'd2,
        SEL_PRBS31 = 3'd3,
        SEL_SINE   = 3'd4,
        SEL_SAW    = 3'd5,
        SEL_TRI    = 3'd6,
        SEL_SQUARE = 3'd7
    } pat_sel_e;

    localparam int NUM_PRBS = 4;
    localparam int MAX_LEN  = 31;

    // Register length of PRBS lane idx.
    function automatic int prbs_len(input int idx);
        case (idx)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // Second feedback tap of PRBS lane idx.
    function automatic int prbs_tap(input int idx);
        case (idx)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction
endpackage

// File: rtl/prbs_lane.sv
// Combinational unroll of one Fibonacci LFSR (x^LEN + x^TAP + 1) over
// WORD_W steps. Bit i of word_o is the i-th generated bit. Assumes TAP < LEN.
module prbs_lane #(
    parameter int LEN    = 7,
    parameter int TAP    = 6,
    parameter int WORD_W = 64
) (
    input  logic [LEN-1:0]    st_i,
    output logic [WORD_W-1:0] word_o,
    output logic [LEN-1:0]    nxt_o
);
    // Step the register WORD_W times and collect the new bits.
    always_comb begin : unroll
        logic [LEN-1:0] s;
        logic           b;
        s = st_i;
        word_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            b = s[LEN-1] ^ s[TAP-1];
            word_o[i] = b;
            s = {s[LEN-2:0], b};
        end
        nxt_o = s;
    end
endmodule

// File: rtl/prbs_engine.sv
// Shared PRBS state register with one unrolled lane per polynomial. The
// active lane picks the next state and word. Assumes lane_i is stable
// between reseeds.
module prbs_engine #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reseed_i,
    input  logic              adv_i,
    input  logic [1:0]        lane_i,
    output logic [WORD_W-1:0] word_o
);
    import tpg_pkg::*;

    logic [MAX_LEN-1:0] state_q;
    logic [MAX_LEN-1:0] nxt_all  [NUM_PRBS];
    logic [WORD_W-1:0]  word_all [NUM_PRBS];

    for (genvar g = 0; g < NUM_PRBS; g++) begin : g_lane
        localparam int L = prbs_len(g);
        localparam int T = prbs_tap(g);
        logic [L-1:0] nxt_g;

        prbs_lane #(.LEN(L), .TAP(T), .WORD_W(WORD_W)) u_lane (
            .st_i   (state_q[L-1:0]),
            .word_o (word_all[g]),
            .nxt_o  (nxt_g)
        );

        if (L < MAX_LEN) begin : g_pad
            assign nxt_all[g] = {state_q[MAX_LEN-1:L], nxt_g};
        end else begin : g_full
            assign nxt_all[g] = nxt_g;
        end

        // An all-zero register would lock the stream at zero forever.
        assert_lfsr_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_i == 2'(g)) |-> (|state_q[L-1:0]))
            else $error("PRBS lane %0d register reached zero", g);
    end

    assign word_o = word_all[lane_i];

    // State update: seed on reset/reselect, advance one word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed_i) begin
            state_q <= '1;
        end else if (adv_i) begin
            state_q <= nxt_all[lane_i];
        end
    end
endmodule

// File: rtl/wave_engine.sv
// Phase-accumulator waveform source. Each word packs WORD_W/SAMP_W
// consecutive signed samples, the lowest sample first. The sine uses a
// quarter-wave table computed at elaboration. Assumes SAMP_W >= 8.
module wave_engine #(
    parameter int WORD_W = 64,
    parameter int SAMP_W = 16,
    parameter int STEP   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reseed_i,
    input  logic              adv_i,
    input  logic [1:0]        shape_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int PER_WORD = WORD_W / SAMP_W;
    localparam int QTR_BITS = 6;
    localparam int LUT_N    = 1 << QTR_BITS;
    localparam int MAG_W    = SAMP_W - 1;
    localparam logic [SAMP_W-1:0] MSB_ONLY = {1'b1, {(SAMP_W-1){1'b0}}};
    localparam logic [SAMP_W-1:0] WORD_ADV = SAMP_W'(PER_WORD * STEP);

    // Quarter-sine magnitudes at bin centres (rational sine approximation).
    function automatic logic [LUT_N-1:0][MAG_W-1:0] build_sine();
        logic [LUT_N-1:0][MAG_W-1:0] t;
        longint u, d, p, den, full;
        full = (longint'(1) << MAG_W) - 1;
        for (int i = 0; i < LUT_N; i++) begin
            u   = 2 * i + 1;
            d   = 90 * u;
            p   = d * (180 * 2 * LUT_N - d);
            den = 40500 * (2 * LUT_N) * (2 * LUT_N) - p;
            t[i] = MAG_W'((full * 4 * p) / den);
        end
        return t;
    endfunction

    localparam logic [LUT_N-1:0][MAG_W-1:0] SINE_LUT = build_sine();

    logic [SAMP_W-1:0] phase_q;

    // Map one phase value to a sample of the chosen shape.
    function automatic logic [SAMP_W-1:0] shape_sample(input logic [1:0] shp,
                                                      input logic [SAMP_W-1:0] ph);
        logic [QTR_BITS-1:0] idx;
        logic [MAG_W-1:0]    mag;
        logic [SAMP_W-1:0]   t;
        idx = ph[SAMP_W-3 -: QTR_BITS];
        mag = SINE_LUT[ph[SAMP_W-2] ? ~idx : idx];
        t   = ph[SAMP_W-1] ? ~{ph[SAMP_W-2:0], 1'b0} : {ph[SAMP_W-2:0], 1'b0};
        case (shp)
            2'd0:    return ph[SAMP_W-1] ? -{1'b0, mag} : {1'b0, mag};
            2'd1:    return ph ^ MSB_ONLY;
            2'd2:    return t ^ MSB_ONLY;
            default: return ph[SAMP_W-1] ? MSB_ONLY : ~MSB_ONLY;
        endcase
    endfunction

    for (genvar k = 0; k < PER_WORD; k++) begin : g_samp
        logic [SAMP_W-1:0] ph_k;
        assign ph_k = phase_q + SAMP_W'(k * STEP);
        assign word_o[k*SAMP_W +: SAMP_W] = shape_sample(shape_i, ph_k);
    end

    // Phase update: zero on reset/reselect, one word of samples per advance.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed_i) begin
            phase_q <= '0;
        end else if (adv_i) begin
            phase_q <= phase_q + WORD_ADV;
        end
    end
endmodule

// File: rtl/test_pattern_gen.sv
// Top of the test pattern generator. It registers the selection, restarts
// the sources on a change and registers the output word. Error injection
// flips bit 0 of a PRBS word only. Assumes pat_sel comes from the same
// clock domain.
module test_pattern_gen #(
    parameter int WORD_W     = 64,
    parameter int SAMP_W     = 16,
    parameter int PHASE_STEP = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pat_sel,
    input  logic              gen_en,
    input  logic              err_inject,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_valid
);
    import tpg_pkg::*;

    localparam int PER_WORD = WORD_W / SAMP_W;

    logic [2:0]        sel_q;
    logic              sel_change, adv;
    logic [WORD_W-1:0] prbs_word, wave_word, next_word;

    assign sel_change = gen_en && (pat_sel != sel_q);
    assign adv        = gen_en && !sel_change;

    prbs_engine #(.WORD_W(WORD_W)) u_prbs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reseed_i (sel_change),
        .adv_i    (adv),
        .lane_i   (sel_q[1:0]),
        .word_o   (prbs_word)
    );

    wave_engine #(.WORD_W(WORD_W), .SAMP_W(SAMP_W), .STEP(PHASE_STEP)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .reseed_i (sel_change),
        .adv_i    (adv),
        .shape_i  (sel_q[1:0]),
        .word_o   (wave_word)
    );

    // Pick the source word; corrupt bit 0 only for PRBS on request.
    always_comb begin
        if (!sel_q[2]) next_word = prbs_word ^ {{(WORD_W-1){1'b0}}, err_inject};
        else           next_word = wave_word;
    end

    // Output and selection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= SEL_PRBS7;
            tx_data  <= '0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= adv;
            if (sel_change) sel_q <= pat_sel;
            if (adv)        tx_data <= next_word;
        end
    end

    assert_reseed_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && pat_sel != sel_q) |=> !tx_valid)
        else $error("valid high after a selection change");

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!tx_valid && $stable(tx_data)))
        else $error("output moved while disabled");

    for (genvar k = 0; k < PER_WORD; k++) begin : g_sq_chk
        assert_square_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && sel_q == SEL_SQUARE) |->
            (tx_data[k*SAMP_W +: SAMP_W] == {1'b0, {(SAMP_W-1){1'b1}}} ||
             tx_data[k*SAMP_W +: SAMP_W] == {1'b1, {(SAMP_W-1){1'b0}}}))
            else $error("square sample %0d off level", k);
    end
endmodule

// File: tb/sim_test_pattern_gen.sv
module sim_test_pattern_gen;
    localparam int STEP = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pat_sel = 3'd0;
    logic        gen_en = 1'b0;
    logic        err_inject = 1'b0;
    logic [63:0] tx_data;
    logic        tx_valid;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [2:0]  cur_sel;
    logic [30:0] hist;
    int          widx;
    logic [15:0] sine_s [256];

    always #2.5 clk = ~clk;

    test_pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .gen_en(gen_en),
        .err_inject(err_inject), .tx_data(tx_data), .tx_valid(tx_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int len_of(input logic [2:0] s);
        case (s) 3'd0: return 7; 3'd1: return 15; 3'd2: return 23; default: return 31; endcase
    endfunction

    function automatic int tap_of(input logic [2:0] s);
        case (s) 3'd0: return 6; 3'd1: return 14; 3'd2: return 18; default: return 28; endcase
    endfunction

    // Recurrence model: hist[j] holds the bit generated j+1 steps ago.
    task automatic next_prbs(output logic [63:0] w);
        logic b;
        for (int i = 0; i < 64; i++) begin
            b = hist[len_of(cur_sel)-1] ^ hist[tap_of(cur_sel)-1];
            w[i] = b;
            hist = {hist[29:0], b};
        end
    endtask

    function automatic logic [15:0] wexp(input logic [2:0] s, input int n);
        logic [15:0] ph, t;
        ph = 16'(n * STEP);
        t  = ph[15] ? ~{ph[14:0], 1'b0} : {ph[14:0], 1'b0};
        case (s)
            3'd5:    return ph ^ 16'h8000;
            3'd6:    return t ^ 16'h8000;
            default: return ph[15] ? 16'h8000 : 16'h7FFF;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; gen_en = 1'b0; err_inject = 1'b0; pat_sel = 3'd0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check(tx_valid == 1'b0, "R7 valid", 64'(tx_valid), 64'd0);
        check(tx_data == 64'd0, "R7 data", tx_data, 64'd0);
        cur_sel = 3'd0; hist = '1; widx = 0;
    endtask

    task automatic select(input logic [2:0] s);
        pat_sel = s; gen_en = 1'b1;
        if (s != cur_sel) begin
            tick();
            check(tx_valid == 1'b0, "R5 gap", 64'(tx_valid), 64'd0);
            cur_sel = s; hist = '1; widx = 0;
        end
    endtask

    task automatic prbs_words(input int n, input string req);
        logic [63:0] w;
        for (int i = 0; i < n; i++) begin
            tick();
            next_prbs(w);
            check(tx_valid && tx_data == w, req, tx_data, w);
        end
    endtask

    task automatic t_err_inject();
        logic [63:0] w;
        err_inject = 1'b1;
        tick();
        err_inject = 1'b0;
        next_prbs(w);
        check(tx_valid && tx_data == (w ^ 64'd1), "R3 flipped word", tx_data, w ^ 64'd1);
        prbs_words(3, "R3 following words clean");
    endtask

    task automatic t_pause();
        logic [63:0] held;
        held = tx_data;
        gen_en = 1'b0;
        err_inject = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(!tx_valid && tx_data == held, "R6 hold", tx_data, held);
        end
        err_inject = 1'b0;
        gen_en = 1'b1;
        prbs_words(3, "R6 R4 resume unbroken");
    endtask

    task automatic wave_words(input int n, input string req);
        logic [63:0] e;
        for (int i = 0; i < n; i++) begin
            tick();
            for (int k = 0; k < 4; k++) e[16*k +: 16] = wexp(cur_sel, widx + k);
            widx += 4;
            check(tx_valid && tx_data == e, req, tx_data, e);
        end
    endtask

    task automatic t_sine();
        logic ok;
        select(3'd4);
        for (int i = 0; i < 64; i++) begin
            tick();
            check(tx_valid == 1'b1, "R12 valid", 64'(tx_valid), 64'd1);
            for (int k = 0; k < 4; k++) sine_s[4*i+k] = tx_data[16*k +: 16];
        end
        ok = 1'b1;
        for (int n = 0; n < 63; n++)
            if ($signed(sine_s[n+1]) <= $signed(sine_s[n])) ok = 1'b0;
        check(ok, "R12 rising quarter", 64'(sine_s[1]), 64'(sine_s[0]));
        ok = 1'b1;
        for (int n = 64; n < 128; n++) if (sine_s[n] != sine_s[127-n]) ok = 1'b0;
        check(ok, "R12 quarter mirror", 64'(sine_s[64]), 64'(sine_s[63]));
        ok = 1'b1;
        for (int n = 0; n < 128; n++) if (sine_s[n+128] != 16'(-sine_s[n])) ok = 1'b0;
        check(ok, "R12 half negation", 64'(sine_s[128]), 64'(16'(-sine_s[0])));
        check($signed(sine_s[63]) > 32700, "R12 peak", 64'(sine_s[63]), 64'd32700);
        check($signed(sine_s[0]) > 0 && $signed(sine_s[0]) < 1000, "R12 start", 64'(sine_s[0]), 64'd0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        select(3'd0);
        prbs_words(10, "R1 R2 PRBS7 from reset");
        t_err_inject();
        select(3'd1);
        prbs_words(8, "R1 PRBS15");
        t_err_inject();
        t_pause();
        select(3'd2);
        prbs_words(6, "R1 PRBS23");
        select(3'd3);
        prbs_words(6, "R1 PRBS31");
        select(3'd5);
        err_inject = 1'b1;
        wave_words(20, "R9 R8 R4 sawtooth");
        err_inject = 1'b0;
        select(3'd6);
        wave_words(70, "R10 R8 triangle");
        select(3'd7);
        wave_words(20, "R11 square");
        t_sine();
        select(3'd0);
        prbs_words(4, "R2 R5 PRBS7 restarted");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule